// File: doc/BRIEF.md
# Double-Buffered 10-bit PWM Generator

This block drives a pulse-width modulated output whose frequency and high time software sets through three write-only registers. One register sets the period (8 bits). Two registers set the duty: an 8-bit upper part and a 2-bit lower part. A 10-bit time base is made of an 8-bit timer with two sub-count bits below it. The time base advances once per prescaled tick. The timer wraps at the period value. The output rises at each wrap and falls when the time base reaches the duty value.

Period and duty writes land in software-side registers. They are copied into active registers only when the timer wraps. A mid-period write therefore never shortens or stretches the pulse in progress. The active duty can be read back but not written. While the enable is low, the counters sit at zero, the output and its output-enable are low, and the active registers follow the software values. Raising the enable therefore starts a clean period with the newest settings.

Top module: `dbuf_pwm`

## Requirements
- R1: After reset, `pwm_out`, `pwm_oe` and `duty_rb` are all zero.
- R2: With the active period value P, the output repeats every (P+1)*4*N clock cycles, where N is the prescale ratio.
- R3: With active duty D and 0 < D < (P+1)*4, the output is high for D*N consecutive cycles per period, starting at the wrap.
- R4: With D = 0 the output stays low. With D >= (P+1)*4 it stays high for the whole period.
- R5: Duty and period writes made while running take effect only at the next timer wrap. `duty_rb` changes only at a wrap.
- R6: `psel` picks the prescale ratio N: 0 gives 1, 1 gives 4, and 2 or 3 give 16.
- R7: While `en` is low, `pwm_oe` and `pwm_out` are low a cycle later, the time base is held at zero, and `duty_rb` follows the written duty. `pwm_oe` rises one cycle after `en` rises.
- R8: The active duty is {upper 8 bits, lower 2 bits}, taken from the two duty registers in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| en | input | 1 | Runs the generator and drives the output-enable |
| per_we | input | 1 | Period register write strobe |
| per_wd | input | 8 | Period register write data |
| dhi_we | input | 1 | Duty upper-part write strobe |
| dhi_wd | input | 8 | Duty upper-part write data (duty bits 9:2) |
| dlo_we | input | 1 | Duty lower-part write strobe |
| dlo_wd | input | 2 | Duty lower-part write data (duty bits 1:0) |
| psel | input | 2 | Prescale select |
| duty_rb | output | 10 | Active (latched) duty value |
| pwm_out | output | 1 | PWM output |
| pwm_oe | output | 1 | Output-enable for the PWM pin |

## Verification
The assertions take for granted that every input is a known value, sampled at the rising clock edge, and that reset is applied at the start. They make no assumption about when register writes or prescale changes arrive, so they also hold for writes at any point in a period. The stimulus keeps the prescale select fixed while the generator runs. It loads period and duty while the enable is low, with one exception: a directed case writes the duty mid-period, right after a wrap, to exercise the buffering. Measurement windows span whole periods, so the expected high counts do not depend on the phase.

// File: rtl/dbuf_pwm.sv
module dbuf_pwm #(
  parameter int TW   = 8,
  parameter int SUBW = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en,
  input  logic            per_we,
  input  logic [TW-1:0]   per_wd,
  input  logic            dhi_we,
  input  logic [TW-1:0]   dhi_wd,
  input  logic            dlo_we,
  input  logic [SUBW-1:0] dlo_wd,
  input  logic [1:0]      psel,
  output logic [TW+SUBW-1:0] duty_rb,
  output logic            pwm_out,
  output logic            pwm_oe
);
  localparam int DW  = TW + SUBW;
  localparam int PCW = 4;

  logic [TW-1:0]   per_sw, dhi_sw, per_act, tmr, tmr_n, per_n;
  logic [SUBW-1:0] dlo_sw, sub, sub_n;
  logic [PCW-1:0]  pcnt, pcnt_n, plim;
  logic [DW-1:0]   slave, slave_n;
  logic            out_q, oe_q, out_n;

  assign plim = (psel == 2'd0) ? PCW'(0) : (psel == 2'd1) ? PCW'(3) : PCW'(15);

  wire tick = pcnt >= plim;
  wire wrap = tick && (&sub) && (tmr >= per_act);

  always_comb begin
    tmr_n   = tmr;
    sub_n   = sub;
    per_n   = per_act;
    slave_n = slave;
    pcnt_n  = tick ? '0 : PCW'(pcnt + 1'b1);
    if (tick) begin
      sub_n = SUBW'(sub + 1'b1);
      if (&sub) begin
        if (wrap) begin
          tmr_n   = '0;
          per_n   = per_sw;
          slave_n = {dhi_sw, dlo_sw};
        end else begin
          tmr_n = TW'(tmr + 1'b1);
        end
      end
    end
    if (!en) begin
      tmr_n   = '0;
      sub_n   = '0;
      pcnt_n  = '0;
      per_n   = per_sw;
      slave_n = {dhi_sw, dlo_sw};
    end
    out_n = en && ({tmr_n, sub_n} < slave_n);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      per_sw  <= '0;
      dhi_sw  <= '0;
      dlo_sw  <= '0;
      per_act <= '0;
      slave   <= '0;
      tmr     <= '0;
      sub     <= '0;
      pcnt    <= '0;
      out_q   <= 1'b0;
      oe_q    <= 1'b0;
    end else begin
      if (per_we) per_sw <= per_wd;
      if (dhi_we) dhi_sw <= dhi_wd;
      if (dlo_we) dlo_sw <= dlo_wd;
      per_act <= per_n;
      slave   <= slave_n;
      tmr     <= tmr_n;
      sub     <= sub_n;
      pcnt    <= pcnt_n;
      out_q   <= out_n;
      oe_q    <= en;
    end
  end

  assign duty_rb = slave;
  assign pwm_out = out_q;
  assign pwm_oe  = oe_q;

  p_tmr_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
    tmr <= per_act);

  p_zero_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (slave == '0) |-> !pwm_out);

  p_full_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pwm_oe && (slave > {per_act, {SUBW{1'b1}}})) |-> pwm_out);

  p_slave_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !wrap) |=> $stable(slave));

  p_off_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!pwm_oe && !pwm_out && tmr == '0 && sub == '0));

  p_oe_on_r7: assert property (@(posedge clk) disable iff (!rst_n)
    en |=> pwm_oe);
endmodule

// File: tb/test_dbuf_pwm.sv
`timescale 1ns/1ps
module test_dbuf_pwm;
  logic clk = 1'b0, rst_n = 1'b0, en = 1'b0;
  logic per_we = 0, dhi_we = 0, dlo_we = 0;
  logic [7:0] per_wd = 0, dhi_wd = 0;
  logic [1:0] dlo_wd = 0, psel = 0;
  logic [9:0] duty_rb;
  logic pwm_out, pwm_oe;
  int n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  dbuf_pwm i_dbuf_pwm (.clk, .rst_n, .en, .per_we, .per_wd, .dhi_we, .dhi_wd,
    .dlo_we, .dlo_wd, .psel, .duty_rb, .pwm_out, .pwm_oe);

  function automatic int ratio(input int sel);
    return (sel == 0) ? 1 : (sel == 1) ? 4 : 16;
  endfunction

  function automatic int exp_high(input int p, input int d);
    return (d > (p + 1) * 4) ? (p + 1) * 4 : d;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wr_duty(input int d);
    dhi_wd = 8'(d >> 2); dlo_wd = 2'(d); dhi_we = 1; dlo_we = 1;
    @(negedge clk);
    dhi_we = 0; dlo_we = 0;
  endtask

  task automatic wr_per(input int p);
    per_wd = 8'(p); per_we = 1;
    @(negedge clk);
    per_we = 0;
  endtask

  task automatic run_case(input int p, input int d, input int sel);
    int tp, eh, hi, r1, r2, nr;
    logic prev;
    en = 0;
    @(negedge clk);
    wr_per(p);
    wr_duty(d);
    psel = 2'(sel);
    @(negedge clk);
    en = 1;
    @(negedge clk);
    check(pwm_oe == 1'b1, "R7 oe rise", int'(pwm_oe), 1);
    tp = (p + 1) * 4 * ratio(sel);
    eh = exp_high(p, d) * ratio(sel);
    repeat (tp + 3) @(negedge clk);
    check(duty_rb == 10'(d), "R8 duty readback", int'(duty_rb), d);
    hi = 0; nr = 0; r1 = 0; r2 = 0; prev = pwm_out;
    for (int i = 0; i < 2 * tp; i++) begin
      @(negedge clk);
      if (pwm_out) hi++;
      if (pwm_out && !prev) begin
        if (nr == 0) r1 = i; else r2 = i;
        nr++;
      end
      prev = pwm_out;
    end
    if (d == 0 || eh == tp)
      check(hi == 2 * eh, "R4 R6 high count", hi, 2 * eh);
    else begin
      check(hi == 2 * eh, "R3 R6 high count", hi, 2 * eh);
      check(nr == 2 && r2 - r1 == tp, "R2 R6 period", r2 - r1, tp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int hc, bad;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    check(pwm_out == 0 && pwm_oe == 0 && duty_rb == 0, "R1 reset state",
          int'(duty_rb) + int'(pwm_out) + int'(pwm_oe), 0);
    rst_n = 1;
    @(negedge clk);
    wr_duty(77);
    @(negedge clk);
    check(duty_rb == 10'd77, "R7 readback tracks while off", int'(duty_rb), 77);
    check(pwm_out == 0 && pwm_oe == 0, "R7 outputs off", int'(pwm_out), 0);

    run_case(0, 2, 0);
    run_case(0, 4, 0);
    run_case(3, 0, 1);
    run_case(255, 700, 0);
    run_case(7, 100, 2);
    run_case(5, 23, 3);
    run_case(2, 9, 1);
    for (int k = 0; k < 10; k++) begin
      int p, d, s;
      p = int'($urandom % 16);
      d = int'($urandom % ((p + 1) * 4 + 4));
      s = int'($urandom % 4);
      run_case(p, d, s);
    end

    run_case(15, 20, 0);
    while (!(pwm_out == 0)) @(negedge clk);
    while (pwm_out == 0) @(negedge clk);
    hc = 1;
    wr_duty(40);
    if (pwm_out) hc++;
    while (pwm_out) begin
      @(negedge clk);
      if (pwm_out) hc++;
    end
    check(hc == 20, "R5 current pulse keeps old duty", hc, 20);
    bad = 0;
    while (pwm_out == 0) begin
      if (duty_rb != 10'd20) bad++;
      @(negedge clk);
    end
    check(bad == 0, "R5 readback held until wrap", bad, 0);
    check(duty_rb == 10'd40, "R5 readback at wrap", int'(duty_rb), 40);
    hc = 0;
    while (pwm_out) begin
      hc++;
      @(negedge clk);
    end
    check(hc == 40, "R5 next pulse uses new duty", hc, 40);

    en = 0;
    @(negedge clk);
    check(pwm_oe == 0 && pwm_out == 0, "R7 disable", int'(pwm_oe), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule